// File: doc/BRIEF.md
# LPC I/O Target Responder

This block is the peripheral side of the four-bit Low Pin Count bus for I/O cycles. It watches the active-low frame strobe and the shared nibble lines and decodes the start code, the cycle type and a 16-bit address sent over four clocks. When the address falls inside a window set by parameters, it takes the bus after the first turn-around. It then drives sync and, for reads, a data byte, and it returns the bus through the final turn-around. Memory, DMA and firmware cycles, addresses outside the window, and any start code other than the target code all leave the block silent.

The local side is a plain register port. A one-cycle write strobe comes with the decoded address and the write byte. A one-cycle read strobe asks for a byte, and that byte must be on `reg_rdata_i` in the ready-sync clock, which comes a fixed number of wait states later. A local error flag, sampled in that same clock, changes the ready code into the error code. The bidirectional bus is split into an input nibble, an output nibble and an output enable.

Top module: `lpc_io_target`

## Requirements
- R1: While `rst_ni` is low, `bus_oe_o`, `reg_wr_o` and `reg_rd_o` are all 0.
- R2: A cycle begins only when the nibble sampled on the last clock with `frame_ni` low is 0000. Any other start code, including the abort code 1111, leaves `bus_oe_o` low for the whole cycle.
- R3: On the clock after the frame, bits [3:1] of the nibble select the cycle type: 000 is an I/O read and 001 is an I/O write. Every other type leaves the target silent.
- R4: The address comes in over 4 clocks, most significant nibble first. The target responds only if (address & ADDR_MASK) == (BASE_ADDR & ADDR_MASK). Otherwise `bus_oe_o` stays low for the whole cycle.
- R5: For a write, the host sends the data byte over 2 clocks after the address, low nibble first. `reg_wr_o` pulses for exactly one clock, the first turn-around clock, with `reg_addr_o` and `reg_wdata_o` valid.
- R6: The target does not drive during either of the 2 clocks of the first turn-around. It first drives in the first sync clock.
- R7: Sync is WAIT_STATES clocks of 0101 followed by one clock of 0000, or 1010 if `reg_err_i` is high in that clock. No other sync code is ever driven.
- R8: For a read, `reg_rd_o` pulses for exactly one clock, the first turn-around clock. `reg_rdata_i` is captured in the ready-sync clock and driven over the next 2 clocks, low nibble first.
- R9: The final turn-around drives 1111 with `bus_oe_o` high for one clock, then releases the bus. The target is then idle and ready for a new start on the next clock.
- R10: `frame_ni` low at any point in a cycle drops `bus_oe_o` in that same clock and restarts start-code decoding.
- R11: When the frame is held low for several clocks, only the last nibble counts. 1111,1111,0000 starts a cycle, and 0000,1111 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame strobe, active low |
| bus_i | input | 4 | Nibble lines as seen on the bus |
| bus_o | output | 4 | Nibble driven by the target |
| bus_oe_o | output | 1 | Target output enable |
| reg_addr_o | output | ADDR_W | Decoded I/O address |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write byte |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read byte, valid in the ready-sync clock |
| reg_err_i | input | 1 | Local error, sampled in the ready-sync clock |

## Verification
The bench builds the block with BASE_ADDR 0x0370, ADDR_MASK 0xFFF0 and WAIT_STATES 3. This gives a 16-byte window that is written and read back in full, with error sync on its top byte, and each response carries three short-wait clocks before ready. It sweeps all 16 start codes and all 16 cycle-type nibbles. It also sends addresses just outside the window on each side and in the top nibble, plus aborts and restarts in mid-cycle and multi-clock frames. Every bus clock is compared against an expected nibble and enable computed from the slot arithmetic.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FRAME, S_ADDR, S_WDATA, S_TAR1, S_SYNC, S_RDATA, S_TAR2
  } state_e;

  localparam logic [3:0] START_TGT  = 4'h0;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_SHORT = 4'h5;
  localparam logic [3:0] SYNC_ERR   = 4'hA;
  localparam logic [3:0] NIB_HIGH   = 4'hF;
  localparam logic [1:0] CT_IO      = 2'b00;  // bits [3:2] of the type nibble
endpackage

// File: rtl/lpc_step_ctr.sv
module lpc_step_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // saturating: an exhausted phase counter stays at zero (R7)
  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/lpc_addr_match.sv
module lpc_addr_match #(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter logic [ADDR_W-1:0] ADDR_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] BASE_M = BASE_ADDR & ADDR_MASK;

  assign hit_o = ((addr_i & ADDR_MASK) == BASE_M);
endmodule

// File: rtl/lpc_drive_mux.sv
module lpc_drive_mux
  import lpc_tgt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_ni,
  input  state_e     state_i,
  input  logic       cnt_zero_i,
  input  logic       first_i,
  input  logic       err_i,
  input  logic [7:0] rdata_i,
  output logic       oe_o,
  output logic [3:0] nib_o
);
  logic drive;

  always_comb begin
    drive = 1'b0;
    nib_o = NIB_HIGH;
    unique case (state_i)
      S_SYNC: begin
        drive = 1'b1;
        if (!cnt_zero_i) nib_o = SYNC_SHORT;
        else             nib_o = err_i ? SYNC_ERR : SYNC_READY;
      end
      S_RDATA: begin
        drive = 1'b1;
        nib_o = first_i ? rdata_i[3:0] : rdata_i[7:4];
      end
      S_TAR2: begin
        drive = first_i;
        nib_o = NIB_HIGH;
      end
      default: ;
    endcase
  end

  // a frame strobe pre-empts the target within the same clock
  assign oe_o = drive & frame_ni;

  p_sync_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_SYNC && oe_o) |->
      (nib_o == SYNC_SHORT || nib_o == SYNC_READY || nib_o == SYNC_ERR));
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_tgt_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0370,
  parameter logic [ADDR_W-1:0] ADDR_MASK   = 16'hFFF0,
  parameter int               WAIT_STATES = 3   // 0..15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        bus_i,
  output logic [3:0]        bus_o,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [7:0]        reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [7:0]        reg_rdata_i,
  input  logic              reg_err_i
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int W_WAIT    = $clog2(WAIT_STATES + 1);
  localparam int W_ADDR    = $clog2(ADDR_NIBS);
  localparam int CNT_W     = (W_WAIT > W_ADDR) ? W_WAIT : ((W_ADDR > 1) ? W_ADDR : 1);

  state_e            state_q, state_d;
  logic [3:0]        start_q;
  logic              is_wr_q;
  logic [ADDR_W-1:0] addr_q, addr_shift;
  logic [7:0]        wdata_q, rdata_q;
  logic              hit;
  logic              load, dec, wr_stb, rd_stb;
  logic [CNT_W-1:0]  load_val, cnt;
  logic              cnt_zero, first;

  assign addr_shift = {addr_q[ADDR_W-5:0], bus_i};
  assign first      = (cnt == CNT_W'(1));

  lpc_addr_match #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .ADDR_MASK(ADDR_MASK)
  ) u_match (
    .addr_i(addr_shift),
    .hit_o (hit)
  );

  lpc_step_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .dec_i     (dec),
    .cnt_o     (cnt),
    .zero_o    (cnt_zero)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = CNT_W'(1);
    dec      = 1'b0;
    wr_stb   = 1'b0;
    rd_stb   = 1'b0;
    if (!frame_ni) begin
      state_d = S_FRAME;
    end else begin
      unique case (state_q)
        S_IDLE: ;
        S_FRAME: begin
          if (start_q == START_TGT && bus_i[3:2] == CT_IO) begin
            state_d  = S_ADDR;
            load     = 1'b1;
            load_val = CNT_W'(ADDR_NIBS - 1);
          end else begin
            state_d = S_IDLE;
          end
        end
        S_ADDR: begin
          if (cnt_zero) begin
            load    = 1'b1;
            state_d = !hit ? S_IDLE : (is_wr_q ? S_WDATA : S_TAR1);
          end else dec = 1'b1;
        end
        S_WDATA: begin
          if (cnt_zero) begin load = 1'b1; state_d = S_TAR1; end
          else dec = 1'b1;
        end
        S_TAR1: begin
          wr_stb = first & is_wr_q;
          rd_stb = first & ~is_wr_q;
          if (cnt_zero) begin
            load     = 1'b1;
            load_val = CNT_W'(WAIT_STATES);
            state_d  = S_SYNC;
          end else dec = 1'b1;
        end
        S_SYNC: begin
          if (cnt_zero) begin
            load    = 1'b1;
            state_d = is_wr_q ? S_TAR2 : S_RDATA;
          end else dec = 1'b1;
        end
        S_RDATA: begin
          if (cnt_zero) begin load = 1'b1; state_d = S_TAR2; end
          else dec = 1'b1;
        end
        S_TAR2: begin
          if (cnt_zero) state_d = S_IDLE;
          else dec = 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      start_q <= NIB_HIGH;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (!frame_ni) start_q <= bus_i;  // last nibble under the frame wins
      if (frame_ni && state_q == S_FRAME) is_wr_q <= bus_i[1];
      if (frame_ni && state_q == S_ADDR)  addr_q  <= addr_shift;
      if (frame_ni && state_q == S_WDATA) begin
        if (first) wdata_q[3:0] <= bus_i;
        else       wdata_q[7:4] <= bus_i;
      end
      if (frame_ni && state_q == S_SYNC && cnt_zero) rdata_q <= reg_rdata_i;
    end
  end

  lpc_drive_mux u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .state_i   (state_q),
    .cnt_zero_i(cnt_zero),
    .first_i   (first),
    .err_i     (reg_err_i),
    .rdata_i   (rdata_q),
    .oe_o      (bus_oe_o),
    .nib_o     (bus_o)
  );

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_wr_o    = wr_stb;
  assign reg_rd_o    = rd_stb;

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_wr_o, reg_rd_o}));
  p_wr_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);
  p_rd_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);
  p_take_in_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> (state_q == S_SYNC));
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TAR2 && cnt_zero) |-> !bus_oe_o);
endmodule

// File: tb/lpc_io_target_bench.sv
module lpc_io_target_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] BASE       = 16'h0370;
  localparam logic [15:0] MASK       = 16'hFFF0;
  localparam int          WAITS      = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1;
  logic [3:0]  bus_i = 4'hF;
  logic [3:0]  bus_o;
  logic        bus_oe_o;
  logic [15:0] reg_addr_o;
  logic        reg_wr_o;
  logic [7:0]  reg_wdata_o;
  logic        reg_rd_o;
  logic [7:0]  reg_rdata_i;
  logic        reg_err_i;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem    [16];
  logic [7:0] shadow [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_io_target #(
    .ADDR_W(16), .BASE_ADDR(BASE), .ADDR_MASK(MASK), .WAIT_STATES(WAITS)
  ) u_lpc_io_target (
    .clk_i(clk), .rst_ni(rst_ni), .frame_ni(frame_ni), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .reg_addr_o(reg_addr_o),
    .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o), .reg_rd_o(reg_rd_o),
    .reg_rdata_i(reg_rdata_i), .reg_err_i(reg_err_i)
  );

  // local register file seen by the target
  assign reg_rdata_i = mem[reg_addr_o[3:0]];
  assign reg_err_i   = (reg_addr_o[3:0] == 4'hF);
  always_ff @(posedge clk) if (reg_wr_o) mem[reg_addr_o[3:0]] <= reg_wdata_o;

  // one bus clock: host drives (f, n), target response compared in the same slot
  task automatic slot(input logic f, input logic [3:0] n, input logic e_oe,
                      input logic [3:0] e_o, input logic e_wr, input logic e_rd,
                      input string req);
    @(negedge clk);
    frame_ni = f;
    bus_i    = n;
    #1;
    checks++;
    if (bus_oe_o !== e_oe || (e_oe && bus_o !== e_o) ||
        reg_wr_o !== e_wr || reg_rd_o !== e_rd) begin
      fails++;
      $display("FAIL %s: oe=%0b o=%h wr=%0b rd=%0b expected oe=%0b o=%h wr=%0b rd=%0b",
               req, bus_oe_o, bus_o, reg_wr_o, reg_rd_o, e_oe, e_o, e_wr, e_rd);
    end
  endtask

  // everything after the frame clock(s)
  task automatic io_body(input logic started, input logic [3:0] ct,
                         input logic [15:0] a, input logic [7:0] wd);
    logic  wr, take;
    string why;
    wr   = ct[1];
    take = started && (ct[3:2] == 2'b00) && ((a & MASK) == (BASE & MASK));
    why  = !started ? "R2" : ((ct[3:2] != 2'b00) ? "R3" : "R4");
    slot(1'b1, ct, 1'b0, 4'h0, 1'b0, 1'b0, why);
    for (int i = 0; i < 4; i++)
      slot(1'b1, a[15-4*i -: 4], 1'b0, 4'h0, 1'b0, 1'b0, why);
    if (!take) begin
      for (int i = 0; i < 10; i++)
        slot(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, why);
    end else begin
      if (wr) begin
        slot(1'b1, wd[3:0], 1'b0, 4'h0, 1'b0, 1'b0, "R5");
        slot(1'b1, wd[7:4], 1'b0, 4'h0, 1'b0, 1'b0, "R5");
      end
      slot(1'b1, 4'hF, 1'b0, 4'h0, wr, !wr, wr ? "R5 R6" : "R8 R6");
      slot(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, "R6");
      for (int w = 0; w < WAITS; w++)
        slot(1'b1, 4'hF, 1'b1, 4'h5, 1'b0, 1'b0, "R7");
      slot(1'b1, 4'hF, 1'b1, (a[3:0] == 4'hF) ? 4'hA : 4'h0, 1'b0, 1'b0, "R7");
      if (!wr) begin
        slot(1'b1, 4'hF, 1'b1, shadow[a[3:0]][3:0], 1'b0, 1'b0, "R8");
        slot(1'b1, 4'hF, 1'b1, shadow[a[3:0]][7:4], 1'b0, 1'b0, "R8");
      end
      slot(1'b1, 4'hF, 1'b1, 4'hF, 1'b0, 1'b0, "R9");
      slot(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, "R9");
      if (wr) shadow[a[3:0]] = wd;
    end
  endtask

  task automatic io_txn(input logic [3:0] st, input logic [3:0] ct,
                        input logic [15:0] a, input logic [7:0] wd);
    slot(1'b0, st, 1'b0, 4'h0, 1'b0, 1'b0, "R2");
    io_body(st == 4'h0, ct, a, wd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (3) @(negedge clk);
    checks++;
    if (bus_oe_o !== 1'b0 || reg_wr_o !== 1'b0 || reg_rd_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: oe=%0b wr=%0b rd=%0b expected 0 0 0", bus_oe_o, reg_wr_o, reg_rd_o);
    end
    rst_ni = 1'b1;
    slot(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, "R1");

    // R5 R7 fill the whole window, then R8 read back
    for (int i = 0; i < 16; i++)
      io_txn(4'h0, 4'h2, BASE | 16'(i), 8'(i * 37 + 5));
    for (int i = 0; i < 16; i++)
      io_txn(4'h0, 4'h0, BASE | 16'(i), 8'h00);

    // R4 misses: no response, and register contents untouched
    io_txn(4'h0, 4'h2, 16'h0360, 8'hAA);
    io_txn(4'h0, 4'h2, 16'h0380, 8'hAA);
    io_txn(4'h0, 4'h3, 16'h8370, 8'hAA);
    io_txn(4'h0, 4'h0, 16'h036F, 8'h00);
    for (int i = 0; i < 16; i++)
      io_txn(4'h0, 4'h0, BASE | 16'(i), 8'h00);

    // R3 all type nibbles (odd LSB is don't-care)
    for (int c = 0; c < 16; c++)
      io_txn(4'h0, 4'(c), 16'h0372, 8'(8'hC0 + c));
    // R2 all start codes
    for (int s = 0; s < 16; s++)
      io_txn(4'(s), 4'h0, 16'h0372, 8'h00);

    // R10 frame during sync: released at once, abort code idles the target
    slot(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    slot(1'b1, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 4; i++)
      slot(1'b1, 4'(16'h0374 >> (12 - 4*i)), 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    slot(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b1, "R10");
    slot(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    slot(1'b1, 4'hF, 1'b1, 4'h5, 1'b0, 1'b0, "R10");
    slot(1'b0, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 8; i++)
      slot(1'b1, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    io_txn(4'h0, 4'h0, 16'h0374, 8'h00);

    // R10 frame with a new start during write data: restarts cleanly
    slot(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    slot(1'b1, 4'h2, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 4; i++)
      slot(1'b1, 4'(16'h0375 >> (12 - 4*i)), 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    slot(1'b1, 4'h9, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    slot(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    io_body(1'b1, 4'h0, 16'h0375, 8'h00);

    // R11 long frames: last nibble decides
    slot(1'b0, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, "R11");
    slot(1'b0, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, "R11");
    slot(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, "R11");
    io_body(1'b1, 4'h0, 16'h037F, 8'h00);
    slot(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, "R11");
    slot(1'b0, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, "R11");
    io_body(1'b0, 4'h0, 16'h037F, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule